// File: doc/BRIEF.md
# Miss Status Holding Table

This block keeps the bookkeeping for cache misses that are still outstanding. Each slot holds a block address, a secure flag, an uncacheable flag, an in-service flag and two counters of waiting targets: a normal list and a deferred list. When a new access misses, the cache controller presents its block address and secure state on the lookup port. The block answers in the same cycle with the lowest-indexed matching slot and a bitmap of every matching slot. The controller then either appends the access as a target of that slot or allocates a fresh slot.

Slots opened for uncacheable accesses take no part in matching, so a cacheable request can never be merged into one of them. Appends are screened in the same cycle. An append is rejected with an error code if it targets a free slot, an uncacheable slot or a full list, or if it is a hardware prefetch. Accepted appends go to the deferred list whenever the slot is already in service and either the deferred list is non-empty or the new target needs exclusive ownership. A read port exposes any slot so that the controller can follow its state.

Top module: `miss_track_file`

## Requirements
- R1: A lookup hits a slot only when that slot is valid, its block address equals `lk_addr` and its secure flag equals `lk_secure`. A difference in either field gives no hit.
- R2: A slot with its uncacheable flag set never appears in `lk_hit`, `lk_idx` or `lk_all`, even when its address and secure flag agree.
- R3: `lk_all` has bit i set exactly when slot i is a valid, cacheable slot whose address and secure flag match the lookup.
- R4: `lk_idx` is the lowest index set in `lk_all`. `lk_hit` is 1 when any bit is set and 0 otherwise.
- R5: `al_idx` shows the lowest free slot. An allocate with `al_en` writes that slot as valid, with the given address, secure and uncacheable flags, not in service, a normal count of 1 and a deferred count of 0. No match is made first.
- R6: An append to an uncacheable slot returns `ap_err` = 1 and leaves the slot unchanged.
- R7: An append with `ap_prefetch` set returns `ap_err` = 2 and leaves the slot unchanged.
- R8: An accepted append (`ap_err` = 0) goes to the deferred list (`ap_deferred` = 1) when the slot is in service and either its deferred count is non-zero or `ap_excl` is set. Otherwise it goes to the normal list. The chosen count rises by one.
- R9: Each list holds at most 4 targets. An append to a full list returns `ap_err` = 3 and changes nothing.
- R10: A deallocate clears the valid flag, the in-service flag and both counts of the slot in the cycle it is issued.
- R11: An append to a free slot returns `ap_err` = 4 and changes nothing. The error codes are checked in this priority order: 4, then 1, then 2, then 3.
- R12: `tbl_full` is 1 when no slot is free. An allocate while full changes nothing. `sv_en` marks a valid slot as in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 26 | Lookup block address |
| lk_secure | input | 1 | Lookup secure state |
| lk_hit | output | 1 | Some slot matches |
| lk_idx | output | 3 | Lowest matching slot |
| lk_all | output | 8 | Bitmap of all matching slots |
| al_en | input | 1 | Allocate strobe |
| al_addr | input | 26 | Address for the new slot |
| al_secure | input | 1 | Secure flag for the new slot |
| al_uncache | input | 1 | Uncacheable flag for the new slot |
| al_idx | output | 3 | Lowest free slot, the one the next allocate takes |
| tbl_full | output | 1 | No free slot |
| ap_en | input | 1 | Append strobe |
| ap_idx | input | 3 | Slot to append to |
| ap_excl | input | 1 | New target needs exclusive ownership |
| ap_prefetch | input | 1 | New target is a hardware prefetch |
| ap_err | output | 3 | Append outcome: 0 ok, 1 uncacheable, 2 prefetch, 3 overflow, 4 free slot |
| ap_deferred | output | 1 | Accepted append goes to the deferred list |
| sv_en | input | 1 | Mark slot as in service |
| sv_idx | input | 3 | Slot to mark |
| dl_en | input | 1 | Deallocate strobe |
| dl_idx | input | 3 | Slot to release |
| rd_idx | input | 3 | Slot to read |
| rd_valid | output | 1 | Read slot valid |
| rd_secure | output | 1 | Read slot secure flag |
| rd_uncache | output | 1 | Read slot uncacheable flag |
| rd_in_svc | output | 1 | Read slot in service |
| rd_addr | output | 26 | Read slot block address |
| rd_norm_cnt | output | 3 | Read slot normal target count |
| rd_def_cnt | output | 3 | Read slot deferred target count |

## Verification
The bench places an uncacheable slot with the same address and secure state as two cacheable slots. A design that ignored the uncacheable flag would report that slot in the bitmap, or as the first hit once the others were freed. It also looks up an address that is present only under the other secure state, which catches a match on address alone. On one in-service slot it drives the deferral rule through every branch: an empty deferred list with and without the exclusive bit, then a non-empty deferred list. A design with the wrong routing shows the wrong count rise. Rejected appends (uncacheable, prefetch, free slot, full list) are followed by a read of the slot, so an error that still bumped a count shows up. The fill-to-full sequence catches a wrong lowest-free choice and an allocate that overwrites a slot while full.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int MT_ADDR_W    = 26;
    localparam int MT_TGT_DEPTH = 4;
    localparam int MT_CNT_W     = $clog2(MT_TGT_DEPTH + 1);

    typedef struct packed {
        logic                 valid;
        logic                 secure;
        logic                 uncache;
        logic                 in_svc;
        logic [MT_ADDR_W-1:0] addr;
        logic [MT_CNT_W-1:0]  n_cnt;
        logic [MT_CNT_W-1:0]  d_cnt;
    } mt_entry_t;

    typedef enum logic [2:0] {
        MT_OK         = 3'd0,
        MT_E_UNCACHE  = 3'd1,
        MT_E_PREFETCH = 3'd2,
        MT_E_OVERFLOW = 3'd3,
        MT_E_INVALID  = 3'd4
    } mt_err_e;

    function automatic logic mt_to_deferred(mt_entry_t e, logic excl);
        return e.in_svc && ((e.d_cnt != '0) || excl);
    endfunction

    function automatic logic mt_same_line(mt_entry_t e, logic [MT_ADDR_W-1:0] a, logic s);
        return e.valid && !e.uncache && (e.addr == a) && (e.secure == s);
    endfunction
endpackage

// File: rtl/mt_prio.sv
module mt_prio #(
    parameter int N    = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/mt_match.sv
module mt_match
    import mt_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  mt_entry_t [N-1:0]       tbl,
    input  logic [MT_ADDR_W-1:0]    addr,
    input  logic                    secure,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx,
    output logic [N-1:0]            vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign vec[g] = mt_same_line(tbl[g], addr, secure);
    end

    mt_prio #(.N(N), .IDX_W(IDX_W)) u_first (
        .req (vec),
        .any (hit),
        .idx (idx)
    );
endmodule

// File: rtl/mt_append_decide.sv
module mt_append_decide
    import mt_pkg::*;
(
    input  mt_entry_t ent,
    input  logic      excl,
    input  logic      prefetch,
    output mt_err_e   err,
    output logic      to_def
);
    always_comb begin
        to_def = mt_to_deferred(ent, excl);
        if (!ent.valid)
            err = MT_E_INVALID;
        else if (ent.uncache)
            err = MT_E_UNCACHE;
        else if (prefetch)
            err = MT_E_PREFETCH;
        else if (to_def ? (ent.d_cnt >= MT_CNT_W'(MT_TGT_DEPTH))
                        : (ent.n_cnt >= MT_CNT_W'(MT_TGT_DEPTH)))
            err = MT_E_OVERFLOW;
        else
            err = MT_OK;
    end
endmodule

// File: rtl/miss_track_file.sv
module miss_track_file
    import mt_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [MT_ADDR_W-1:0]   lk_addr,
    input  logic                   lk_secure,
    output logic                   lk_hit,
    output logic [IDX_W-1:0]       lk_idx,
    output logic [NUM_ENTRIES-1:0] lk_all,
    input  logic                   al_en,
    input  logic [MT_ADDR_W-1:0]   al_addr,
    input  logic                   al_secure,
    input  logic                   al_uncache,
    output logic [IDX_W-1:0]       al_idx,
    output logic                   tbl_full,
    input  logic                   ap_en,
    input  logic [IDX_W-1:0]       ap_idx,
    input  logic                   ap_excl,
    input  logic                   ap_prefetch,
    output logic [2:0]             ap_err,
    output logic                   ap_deferred,
    input  logic                   sv_en,
    input  logic [IDX_W-1:0]       sv_idx,
    input  logic                   dl_en,
    input  logic [IDX_W-1:0]       dl_idx,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic                   rd_valid,
    output logic                   rd_secure,
    output logic                   rd_uncache,
    output logic                   rd_in_svc,
    output logic [MT_ADDR_W-1:0]   rd_addr,
    output logic [MT_CNT_W-1:0]    rd_norm_cnt,
    output logic [MT_CNT_W-1:0]    rd_def_cnt
);
    mt_entry_t [NUM_ENTRIES-1:0] tbl_q;
    logic [NUM_ENTRIES-1:0]      busy;
    logic                        free_any;
    mt_err_e                     ap_code;
    logic                        ap_to_def;
    mt_entry_t                   rd_ent;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_busy
        assign busy[g] = tbl_q[g].valid;
    end

    mt_match #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_match (
        .tbl    (tbl_q),
        .addr   (lk_addr),
        .secure (lk_secure),
        .hit    (lk_hit),
        .idx    (lk_idx),
        .vec    (lk_all)
    );

    mt_prio #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_free (
        .req (~busy),
        .any (free_any),
        .idx (al_idx)
    );

    mt_append_decide u_decide (
        .ent      (tbl_q[ap_idx]),
        .excl     (ap_excl),
        .prefetch (ap_prefetch),
        .err      (ap_code),
        .to_def   (ap_to_def)
    );

    assign tbl_full    = !free_any;
    assign ap_err      = ap_code;
    assign ap_deferred = ap_to_def;

    // Later statements win: a release overrides service marks and appends.
    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= '0;
        end else begin
            if (al_en && free_any) begin
                tbl_q[al_idx] <= '{valid: 1'b1, secure: al_secure, uncache: al_uncache,
                                   in_svc: 1'b0, addr: al_addr,
                                   n_cnt: MT_CNT_W'(1), d_cnt: '0};
            end
            if (sv_en && tbl_q[sv_idx].valid) begin
                tbl_q[sv_idx].in_svc <= 1'b1;
            end
            if (ap_en && ap_code == MT_OK) begin
                if (ap_to_def)
                    tbl_q[ap_idx].d_cnt <= tbl_q[ap_idx].d_cnt + 1'b1;
                else
                    tbl_q[ap_idx].n_cnt <= tbl_q[ap_idx].n_cnt + 1'b1;
            end
            if (dl_en) begin
                tbl_q[dl_idx] <= '0;
            end
        end
    end

    assign rd_ent      = tbl_q[rd_idx];
    assign rd_valid    = rd_ent.valid;
    assign rd_secure   = rd_ent.secure;
    assign rd_uncache  = rd_ent.uncache;
    assign rd_in_svc   = rd_ent.in_svc;
    assign rd_addr     = rd_ent.addr;
    assign rd_norm_cnt = rd_ent.n_cnt;
    assign rd_def_cnt  = rd_ent.d_cnt;
endmodule

// File: rtl/mt_chk.sv
module mt_chk
    import mt_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_hit,
    input logic [IW-1:0]     lk_idx,
    input logic [N-1:0]      lk_all,
    input logic              al_en,
    input logic [IW-1:0]     al_idx,
    input logic              tbl_full,
    input logic              ap_en,
    input logic [2:0]        ap_err,
    input logic              sv_en,
    input logic              dl_en,
    input logic [IW-1:0]     dl_idx,
    input mt_entry_t [N-1:0] tbl_q
);
    logic [N-1:0] uc_vec;
    always_comb begin
        for (int i = 0; i < N; i++) uc_vec[i] = tbl_q[i].uncache;
    end

    a_r4_hit_in_map: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_all[lk_idx]);

    a_r4_lowest: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ((lk_all & ((N'(1) << lk_idx) - N'(1))) == '0));

    a_r2_no_uncache: assert property (@(posedge clk) disable iff (rst)
        (lk_all & uc_vec) == '0);

    a_r5_alloc_valid: assert property (@(posedge clk) disable iff (rst)
        (al_en && !tbl_full) |=> tbl_q[$past(al_idx)].valid);

    a_r6_reject_stable: assert property (@(posedge clk) disable iff (rst)
        (ap_en && ap_err != 3'd0 && !al_en && !sv_en && !dl_en) |=> $stable(tbl_q));

    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        dl_en |=> (tbl_q[$past(dl_idx)] == '0));
endmodule

bind miss_track_file mt_chk #(.N(NUM_ENTRIES), .IW(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_hit   (lk_hit),
    .lk_idx   (lk_idx),
    .lk_all   (lk_all),
    .al_en    (al_en),
    .al_idx   (al_idx),
    .tbl_full (tbl_full),
    .ap_en    (ap_en),
    .ap_err   (ap_err),
    .sv_en    (sv_en),
    .dl_en    (dl_en),
    .dl_idx   (dl_idx),
    .tbl_q    (tbl_q)
);

// File: tb/test_miss_track_file.sv
module test_miss_track_file;
    localparam int AW = 26;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_secure = 1'b0;
    logic          lk_hit;
    logic [2:0]    lk_idx;
    logic [7:0]    lk_all;
    logic          al_en = 1'b0;
    logic [AW-1:0] al_addr = '0;
    logic          al_secure = 1'b0, al_uncache = 1'b0;
    logic [2:0]    al_idx;
    logic          tbl_full;
    logic          ap_en = 1'b0;
    logic [2:0]    ap_idx = '0;
    logic          ap_excl = 1'b0, ap_prefetch = 1'b0;
    logic [2:0]    ap_err;
    logic          ap_deferred;
    logic          sv_en = 1'b0;
    logic [2:0]    sv_idx = '0;
    logic          dl_en = 1'b0;
    logic [2:0]    dl_idx = '0;
    logic [2:0]    rd_idx = '0;
    logic          rd_valid, rd_secure, rd_uncache, rd_in_svc;
    logic [AW-1:0] rd_addr;
    logic [2:0]    rd_norm_cnt, rd_def_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [AW-1:0] A = 26'h0123;
    localparam logic [AW-1:0] B = 26'h0456;
    localparam logic [AW-1:0] C = 26'h0789;

    always #10 clk = ~clk;

    miss_track_file i_miss_track_file (
        .clk(clk), .rst(rst),
        .lk_addr(lk_addr), .lk_secure(lk_secure), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_all(lk_all),
        .al_en(al_en), .al_addr(al_addr), .al_secure(al_secure), .al_uncache(al_uncache),
        .al_idx(al_idx), .tbl_full(tbl_full),
        .ap_en(ap_en), .ap_idx(ap_idx), .ap_excl(ap_excl), .ap_prefetch(ap_prefetch),
        .ap_err(ap_err), .ap_deferred(ap_deferred),
        .sv_en(sv_en), .sv_idx(sv_idx), .dl_en(dl_en), .dl_idx(dl_idx),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_secure(rd_secure), .rd_uncache(rd_uncache),
        .rd_in_svc(rd_in_svc), .rd_addr(rd_addr), .rd_norm_cnt(rd_norm_cnt), .rd_def_cnt(rd_def_cnt)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic do_alloc(input logic [AW-1:0] a, input logic s, input logic u, output logic [2:0] idx);
        @(negedge clk);
        al_addr = a; al_secure = s; al_uncache = u; al_en = 1'b1;
        #1 idx = al_idx;
        @(posedge clk); #1 al_en = 1'b0;
    endtask

    task automatic do_append(input logic [2:0] i, input logic ex, input logic pf,
                             output logic [2:0] err, output logic def);
        @(negedge clk);
        ap_idx = i; ap_excl = ex; ap_prefetch = pf; ap_en = 1'b1;
        #1 err = ap_err; def = ap_deferred;
        @(posedge clk); #1 ap_en = 1'b0; ap_prefetch = 1'b0; ap_excl = 1'b0;
    endtask

    task automatic do_service(input logic [2:0] i);
        @(negedge clk); sv_idx = i; sv_en = 1'b1;
        @(posedge clk); #1 sv_en = 1'b0;
    endtask

    task automatic do_release(input logic [2:0] i);
        @(negedge clk); dl_idx = i; dl_en = 1'b1;
        @(posedge clk); #1 dl_en = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] a, input logic s);
        @(negedge clk); lk_addr = a; lk_secure = s; #1;
    endtask

    task automatic peek(input logic [2:0] i);
        @(negedge clk); rd_idx = i; #1;
    endtask

    task automatic t_reset();
        look(A, 1'b0);
        chk("R4 no hit after reset", lk_hit, 0);
        chk("R3 empty map after reset", lk_all, 0);
        chk("R12 not full after reset", tbl_full, 0);
        chk("R5 first free slot", al_idx, 0);
        peek(3'd0);
        chk("R10 slot clear after reset", rd_valid, 0);
    endtask

    task automatic t_match();
        logic [2:0] ix;
        do_alloc(A, 1'b0, 1'b0, ix); chk("R5 alloc slot 0", ix, 0);
        do_alloc(A, 1'b1, 1'b0, ix); chk("R5 alloc slot 1", ix, 1);
        do_alloc(B, 1'b0, 1'b0, ix); chk("R5 alloc slot 2", ix, 2);
        do_alloc(A, 1'b0, 1'b1, ix); chk("R5 alloc uncacheable slot 3", ix, 3);
        do_alloc(A, 1'b0, 1'b0, ix); chk("R5 alloc slot 4", ix, 4);
        look(A, 1'b0);
        chk("R4 hit A", lk_hit, 1);
        chk("R4 lowest index A", lk_idx, 0);
        chk("R3 R2 map A excludes uncacheable", lk_all, 8'h11);
        look(A, 1'b1);
        chk("R1 secure A idx", lk_idx, 1);
        chk("R1 secure A map", lk_all, 8'h02);
        look(B, 1'b1);
        chk("R1 secure mismatch no hit", lk_hit, 0);
        look(C, 1'b0);
        chk("R1 address absent", lk_all, 0);
        peek(3'd3);
        chk("R5 uncache flag stored", rd_uncache, 1);
        chk("R5 first target count", rd_norm_cnt, 1);
        chk("R5 address stored", rd_addr, A);
        do_release(3'd0);
        do_release(3'd4);
        look(A, 1'b0);
        chk("R2 only uncacheable left, no hit", lk_hit, 0);
        chk("R2 only uncacheable left, map", lk_all, 0);
        do_alloc(A, 1'b0, 1'b0, ix); chk("R5 reuse lowest free", ix, 0);
    endtask

    task automatic t_errors();
        logic [2:0] e; logic d;
        do_append(3'd3, 1'b0, 1'b0, e, d);
        chk("R6 uncacheable append code", e, 1);
        peek(3'd3);
        chk("R6 uncacheable slot unchanged", rd_norm_cnt, 1);
        do_append(3'd1, 1'b0, 1'b1, e, d);
        chk("R7 prefetch append code", e, 2);
        peek(3'd1);
        chk("R7 slot unchanged", rd_norm_cnt, 1);
        do_append(3'd6, 1'b0, 1'b0, e, d);
        chk("R11 free slot append code", e, 4);
        peek(3'd6);
        chk("R11 free slot stays free", rd_valid, 0);
        do_append(3'd3, 1'b0, 1'b1, e, d);
        chk("R11 priority uncacheable over prefetch", e, 1);
    endtask

    task automatic t_defer();
        logic [2:0] e; logic d;
        do_append(3'd2, 1'b0, 1'b0, e, d);
        chk("R8 idle plain code", e, 0); chk("R8 idle plain normal", d, 0);
        do_append(3'd2, 1'b1, 1'b0, e, d);
        chk("R8 idle exclusive normal", d, 0);
        peek(3'd2);
        chk("R8 normal count 3", rd_norm_cnt, 3);
        do_service(3'd2);
        peek(3'd2);
        chk("R12 in service set", rd_in_svc, 1);
        do_append(3'd2, 1'b0, 1'b0, e, d);
        chk("R8 in service empty deferred plain normal", d, 0);
        do_append(3'd2, 1'b1, 1'b0, e, d);
        chk("R8 in service exclusive deferred", d, 1);
        do_append(3'd2, 1'b0, 1'b0, e, d);
        chk("R8 non-empty deferred list deferred", d, 1);
        peek(3'd2);
        chk("R8 normal count 4", rd_norm_cnt, 4);
        chk("R8 deferred count 2", rd_def_cnt, 2);
        do_append(3'd2, 1'b0, 1'b0, e, d);
        do_append(3'd2, 1'b0, 1'b0, e, d);
        chk("R9 fourth deferred accepted", e, 0);
        do_append(3'd2, 1'b0, 1'b0, e, d);
        chk("R9 deferred overflow code", e, 3);
        peek(3'd2);
        chk("R9 deferred count held", rd_def_cnt, 4);
        for (int k = 0; k < 3; k++) do_append(3'd1, 1'b0, 1'b0, e, d);
        chk("R9 fourth normal accepted", e, 0);
        do_append(3'd1, 1'b0, 1'b0, e, d);
        chk("R9 normal overflow code", e, 3);
        peek(3'd1);
        chk("R9 normal count held", rd_norm_cnt, 4);
    endtask

    task automatic t_full();
        logic [2:0] ix;
        for (int k = 0; k < 8; k++) do_release(3'(k));
        for (int k = 0; k < 8; k++) begin
            do_alloc(C + AW'(k), 1'b0, 1'b0, ix);
            chk("R5 fill in order", ix, k);
        end
        #1 chk("R12 full after eight", tbl_full, 1);
        do_alloc(B, 1'b0, 1'b0, ix);
        look(B, 1'b0);
        chk("R12 alloc while full ignored", lk_hit, 0);
        peek(3'd0);
        chk("R12 slot 0 kept", rd_addr, C);
        do_service(3'd5);
        do_release(3'd5);
        peek(3'd5);
        chk("R10 valid cleared", rd_valid, 0);
        chk("R10 in service cleared", rd_in_svc, 0);
        chk("R10 count cleared", rd_norm_cnt, 0);
        chk("R12 not full after release", tbl_full, 0);
        chk("R5 freed slot offered", al_idx, 5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_match();
        t_errors();
        t_defer();
        t_full();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule